// File: doc/BRIEF.md
# Multiplexed Keypad Debounce Scanner

This block watches a 32-switch key matrix through four sense lines. An external slot tick walks an eight-step group index, and the block exports that index so the matrix can present the four keys of the current group. On each tick the block captures the four sense lines into the pressed state of those keys. A key counts as a new press only when it was not reported before and is seen pressed on two samplings of its group in a row. Every key therefore needs two full scan passes (sixteen slot ticks) to debounce.

Newly confirmed keys set sticky bits in four 8-bit debounced banks. A host port reads any bank of pressed, debounced or mask state and writes the mask banks. Reading a debounced bank returns its contents and then empties it. An interrupt request goes high when a confirmed key has its mask bit enabled. It stays high until the host reads any debounced bank. A key that stays down is reported only once, and it must be sampled open before it can report again.

Top module: `key_debounce_scanner`

## Requirements
- R1: After reset, scanGroup is 0, irq is 0, every pressed and debounced bank reads 0x00 and every mask bank reads 0xFF.
- R2: On a clock edge with slotTick high, keySense[l] is taken as the state of key scanGroup*4+l, and scanGroup then advances by one, wrapping from 7 to 0. scanGroup does not change without slotTick. Key k lives in bank k/8 at bit k%8.
- R3: Each pressed-bank bit holds the most recent sample of its key (1 = closed). It changes only when its key's group is sampled.
- R4: A key debounces on a sampling edge where its stored sample is 1, the new sample is 1 and it has not already been reported. Its debounced bit is set after that edge.
- R5: A key held closed debounces only once. It can debounce again only after one sample of 0 followed by two samples of 1.
- R6: Debounced bits accumulate until read. A read of a debounced bank clears that bank after returning it. A key that debounces on the same edge as the read of its bank keeps its bit set.
- R7: hostWrite with hostKind=0 loads hostWdata into mask bank hostBank. Mask bits never affect sampling, pressed state or debounced bits.
- R8: irq rises on the edge after a debounce whose key has its mask bit set. It is held until an edge with a read of any debounced bank (hostKind=2). A new enabled debounce on that same edge keeps it high.
- R9: Any combination of the four sense lines in a slot is captured and debounced independently (n-key rollover).
- R10: On the edge after hostRead, hostRdata holds the selected bank as it was before that edge: hostKind 0 = mask, 1 = pressed, 2 = debounced, 3 = 0x00. Otherwise hostRdata holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotTick | input | 1 | One-cycle strobe: sample the current group and advance |
| keySense | input | 4 | Closed (1) / open (0) state of the four keys of the current group |
| scanGroup | output | 3 | Index of the key group presented on keySense |
| hostKind | input | 2 | Register kind: 0 mask, 1 pressed, 2 debounced, 3 none |
| hostBank | input | 2 | Bank index (keys 8*bank to 8*bank+7) |
| hostWrite | input | 1 | Write strobe (mask kind only) |
| hostWdata | input | 8 | Write data |
| hostRead | input | 1 | Read strobe; clears a debounced bank |
| hostRdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, level |

## Verification
On every cycle the assertions check the group stepping and its hold without a tick. They check that pressed and mask state move only on their strobes, and that a debounced bit only rises for a key sampled closed twice. They also check that irq holds until a debounced read and drops on a read that brings no new enabled key. Only the bench scenarios can show the end-to-end behaviour across passes. That covers single reporting of a held key and re-arming after release, accumulation across unread debounces, and the survival of a bit that debounces on the edge its bank is cleared. It also covers masking of the interrupt while the key is still captured, and the data returned by each register kind.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  typedef enum logic [1:0] {
    REG_MASK      = 2'd0,
    REG_PRESSED   = 2'd1,
    REG_DEBOUNCED = 2'd2,
    REG_NONE      = 2'd3
  } regKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     sampleEn;   // capture the current group's sense lines
    logic     maskWr;     // load a mask bank
    logic     dbClr;      // read-to-clear of a debounced bank
    logic     rdLoad;     // load the read data register
    regKind_t rdKind;     // register kind for the read mux
  } ctrlStrobes_t;

endpackage

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
  import keyscan_pkg::*;
#(
  parameter int GROUPS     = 8,
  parameter int GROUP_W    = 3,
  parameter int BANK_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotTick,
  input  logic                  hostRead,
  input  logic                  hostWrite,
  input  logic [1:0]            hostKind,
  input  logic [BANK_SEL_W-1:0] hostBank,
  output logic [GROUP_W-1:0]    group,
  output logic [BANK_SEL_W-1:0] bankIdx,
  output ctrlStrobes_t          strobes
);

  localparam logic [GROUP_W-1:0] LAST_GROUP = GROUP_W'(GROUPS - 1);

  regKind_t kind;
  assign kind = regKind_t'(hostKind);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      group <= '0;
    end else if (slotTick) begin
      group <= (group == LAST_GROUP) ? '0 : group + 1'b1;
    end
  end

  always_comb begin
    strobes.sampleEn = slotTick;
    strobes.maskWr   = hostWrite && (kind == REG_MASK);
    strobes.dbClr    = hostRead && (kind == REG_DEBOUNCED);
    strobes.rdLoad   = hostRead;
    strobes.rdKind   = kind;
  end

  assign bankIdx = hostBank;

  assert_group_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    slotTick |=> group == (($past(group) == LAST_GROUP) ? '0 : $past(group) + 1'b1));

  assert_group_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !slotTick |=> $stable(group));

endmodule

// File: rtl/keyscan_datapath.sv
module keyscan_datapath
  import keyscan_pkg::*;
#(
  parameter int KEY_LANES  = 4,
  parameter int NUM_KEYS   = 32,
  parameter int BANK_W     = 8,
  parameter int GROUP_W    = 3,
  parameter int BANK_SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [GROUP_W-1:0]    group,
  input  logic [BANK_SEL_W-1:0] bankIdx,
  input  logic [KEY_LANES-1:0]  keySense,
  input  logic [BANK_W-1:0]     hostWdata,
  output logic [BANK_W-1:0]     hostRdata,
  output logic                  irq
);

  logic [NUM_KEYS-1:0] pressedQ, reportedQ, debouncedQ, maskQ;
  logic [NUM_KEYS-1:0] pressedD, reportedD, debouncedD, maskD;
  logic [NUM_KEYS-1:0] eventVec;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    localparam int GRP  = k / KEY_LANES;
    localparam int LANE = k % KEY_LANES;
    localparam int BANK = k / BANK_W;
    localparam int BIT  = k % BANK_W;

    logic keyHit, sense, clrHit, wrHit;
    assign keyHit = strobes.sampleEn && (group == GROUP_W'(GRP));
    assign sense  = keySense[LANE];
    assign clrHit = strobes.dbClr && (bankIdx == BANK_SEL_W'(BANK));
    assign wrHit  = strobes.maskWr && (bankIdx == BANK_SEL_W'(BANK));

    // second closed sample of a key not yet reported
    assign eventVec[k]   = keyHit && sense && pressedQ[k] && !reportedQ[k];
    assign pressedD[k]   = keyHit ? sense : pressedQ[k];
    assign reportedD[k]  = keyHit ? (sense && (reportedQ[k] || eventVec[k])) : reportedQ[k];
    // a fresh event wins over the clear of its bank
    assign debouncedD[k] = (debouncedQ[k] && !clrHit) || eventVec[k];
    assign maskD[k]      = wrHit ? hostWdata[BIT] : maskQ[k];

    assert_deb_needs_two_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(debouncedQ[k]) |-> pressedQ[k] && $past(pressedQ[k]));

    assert_single_report_R5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(debouncedQ[k]) |-> !$past(reportedQ[k]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pressedQ   <= '0;
      reportedQ  <= '0;
      debouncedQ <= '0;
      maskQ      <= '1;
      irq        <= 1'b0;
    end else begin
      pressedQ   <= pressedD;
      reportedQ  <= reportedD;
      debouncedQ <= debouncedD;
      maskQ      <= maskD;
      irq        <= (|(eventVec & maskQ)) || (irq && !strobes.dbClr);
    end
  end

  logic [BANK_W-1:0] rdMux;
  always_comb begin
    unique case (strobes.rdKind)
      REG_MASK:      rdMux = maskQ[bankIdx*BANK_W +: BANK_W];
      REG_PRESSED:   rdMux = pressedQ[bankIdx*BANK_W +: BANK_W];
      REG_DEBOUNCED: rdMux = debouncedQ[bankIdx*BANK_W +: BANK_W];
      default:       rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdata <= '0;
    else if (strobes.rdLoad) hostRdata <= rdMux;
  end

  assert_pressed_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sampleEn |=> $stable(pressedQ));

  assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.maskWr |=> $stable(maskQ));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq && !strobes.dbClr |=> irq);

  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dbClr && !(|(eventVec & maskQ)) |=> !irq);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdLoad |=> $stable(hostRdata));

endmodule

// File: rtl/key_debounce_scanner.sv
module key_debounce_scanner
  import keyscan_pkg::*;
#(
  parameter int KEY_LANES = 4,
  parameter int GROUPS    = 8,
  parameter int BANK_W    = 8,
  localparam int NUM_KEYS   = KEY_LANES * GROUPS,
  localparam int NUM_BANKS  = NUM_KEYS / BANK_W,
  localparam int GROUP_W    = $clog2(GROUPS),
  localparam int BANK_SEL_W = $clog2(NUM_BANKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotTick,
  input  logic [KEY_LANES-1:0]  keySense,
  output logic [GROUP_W-1:0]    scanGroup,
  input  logic [1:0]            hostKind,
  input  logic [BANK_SEL_W-1:0] hostBank,
  input  logic                  hostWrite,
  input  logic [BANK_W-1:0]     hostWdata,
  input  logic                  hostRead,
  output logic [BANK_W-1:0]     hostRdata,
  output logic                  irq
);

  ctrlStrobes_t          strobes;
  logic [BANK_SEL_W-1:0] bankIdx;

  keyscan_ctrl #(
    .GROUPS(GROUPS), .GROUP_W(GROUP_W), .BANK_SEL_W(BANK_SEL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .slotTick(slotTick),
    .hostRead(hostRead), .hostWrite(hostWrite), .hostKind(hostKind),
    .hostBank(hostBank), .group(scanGroup), .bankIdx(bankIdx),
    .strobes(strobes)
  );

  keyscan_datapath #(
    .KEY_LANES(KEY_LANES), .NUM_KEYS(NUM_KEYS), .BANK_W(BANK_W),
    .GROUP_W(GROUP_W), .BANK_SEL_W(BANK_SEL_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .group(scanGroup),
    .bankIdx(bankIdx), .keySense(keySense), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irq(irq)
  );

endmodule

// File: tb/test_key_debounce_scanner.sv
`timescale 1ns/1ps
module test_key_debounce_scanner;

  logic       clk = 1'b0;
  logic       rstN, slotTick, hostWrite, hostRead;
  logic [3:0] keySense;
  logic [2:0] scanGroup;
  logic [1:0] hostKind, hostBank;
  logic [7:0] hostWdata, hostRdata;
  logic       irq;

  always #4 clk = ~clk;

  key_debounce_scanner i_key_debounce_scanner (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .keySense(keySense),
    .scanGroup(scanGroup), .hostKind(hostKind), .hostBank(hostBank),
    .hostWrite(hostWrite), .hostWdata(hostWdata), .hostRead(hostRead),
    .hostRdata(hostRdata), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model of the requirements
  logic [31:0] mPressed, mRep, mDeb, mMask;
  logic        mIrq;
  logic [2:0]  mGrp;
  logic [7:0]  mRd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit tick, input logic [3:0] sense, input bit rd,
                      input logic [1:0] rk, input logic [1:0] rb, input bit wr,
                      input logic [7:0] wd, input string tag);
    logic [31:0] ev;
    @(negedge clk);
    slotTick = tick; keySense = sense; hostRead = rd; hostKind = rk;
    hostBank = rb; hostWrite = wr; hostWdata = wd;
    ev = '0;
    if (rd) begin
      case (rk)
        2'd0: mRd = mMask[rb*8 +: 8];
        2'd1: mRd = mPressed[rb*8 +: 8];
        2'd2: mRd = mDeb[rb*8 +: 8];
        default: mRd = 8'h00;
      endcase
    end
    if (tick) begin
      for (int l = 0; l < 4; l++) begin
        int k;
        k = mGrp * 4 + l;
        if (sense[l] && mPressed[k] && !mRep[k]) ev[k] = 1'b1;
        mRep[k]     = sense[l] && (mRep[k] || ev[k]);
        mPressed[k] = sense[l];
      end
      mGrp = mGrp + 3'd1;
    end
    mIrq = (|(ev & mMask)) || (mIrq && !(rd && rk == 2'd2));
    if (rd && rk == 2'd2) mDeb[rb*8 +: 8] = 8'h00;
    mDeb = mDeb | ev;
    if (wr && rk == 2'd0) mMask[rb*8 +: 8] = wd;
    @(negedge clk);
    slotTick = 0; hostRead = 0; hostWrite = 0;
    check({tag, " R2 group"}, 32'(scanGroup), 32'(mGrp));
    check({tag, " R8 irq"}, 32'(irq), 32'(mIrq));
    if (rd) check({tag, " R10 rdata"}, 32'(hostRdata), 32'(mRd));
  endtask

  task automatic pass(input logic [31:0] keys, input string tag);
    for (int s = 0; s < 8; s++) step(1'b1, keys[mGrp*4 +: 4], 0, 0, 0, 0, 0, tag);
  endtask

  // second pass with a debounced read of bank rb in the slot of group 2*rb+1
  task automatic passWithRead(input logic [31:0] keys, input logic [1:0] rb);
    for (int s = 0; s < 8; s++)
      step(1'b1, keys[mGrp*4 +: 4], mGrp == {rb, 1'b1}, 2'd2, rb, 0, 0, "R6 collide");
  endtask

  task automatic readAll(input string tag);
    for (int b = 0; b < 4; b++) begin
      step(0, 0, 1, 2'd1, 2'(b), 0, 0, {tag, " R3 pressed"});
      step(0, 0, 1, 2'd2, 2'(b), 0, 0, {tag, " R6 debounced"});
    end
  endtask

  task automatic writeMask(input logic [1:0] b, input logic [7:0] v);
    step(0, 0, 0, 2'd0, b, 1, v, "R7 maskwr");
    step(0, 0, 1, 2'd0, b, 0, 0, "R7 maskrd");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    rstN = 0; slotTick = 0; keySense = 0; hostKind = 0; hostBank = 0;
    hostWrite = 0; hostWdata = 0; hostRead = 0;
    mPressed = 0; mRep = 0; mDeb = 0; mMask = '1; mIrq = 0; mGrp = 0; mRd = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 group", 32'(scanGroup), 0);
    check("R1 irq", 32'(irq), 0);
    for (int b = 0; b < 4; b++) step(0, 0, 1, 2'd0, 2'(b), 0, 0, "R1 mask");
    readAll("R1");
    step(0, 0, 1, 2'd3, 0, 0, 0, "R10 none");

    // every key alone: debounce, hold, release, re-arm (R4, R5)
    for (int k = 0; k < 32; k++) begin
      p = 32'd1 << k;
      pass(p, "R3 first");
      pass(p, "R4 second");
      readAll("R4");
      pass(p, "R5 held");
      readAll("R5 held");
      pass(0, "R5 release");
      pass(p, "R5 again1");
      pass(p, "R5 again2");
      readAll("R5 rearm");
      pass(0, "R5 idle");
    end

    // many keys at once (R9) and accumulation without read (R6)
    p = 32'h1234_5678;
    for (int i = 0; i < 8; i++) begin
      p = (p * 32'd1103515245 + 32'd12345) ^ (p >> 7);
      pass(p, "R9 a1");
      pass(p, "R9 a2");
      pass(0, "R6 rel");
      pass(~p, "R6 b1");
      pass(~p, "R6 b2");
      readAll("R9 R6");
      pass(0, "R9 idle");
    end
    pass(32'hFFFF_FFFF, "R9 all1");
    pass(32'hFFFF_FFFF, "R9 all2");
    readAll("R9 all");
    pass(0, "R9 idle");

    // masks (R7)
    for (int b = 0; b < 4; b++) writeMask(2'(b), 8'h00);
    pass(32'h0000_0401, "R7 m1");
    pass(32'h0000_0401, "R7 m2");
    readAll("R7 off");
    pass(0, "R7 rel");
    writeMask(2'd1, 8'h04);
    pass(32'h0000_0401, "R7 e1");
    pass(32'h0000_0401, "R7 e2");
    readAll("R7 on");
    pass(0, "R7 rel2");
    for (int b = 0; b < 4; b++) writeMask(2'(b), 8'hFF);

    // debounce on the read-clear edge keeps bit and irq (R6, R8)
    p = 32'h0010_0001 | 32'h00F0_0000;
    pass(p, "R6 c1");
    passWithRead(p, 2'd2);
    step(0, 0, 1, 2'd2, 2'd2, 0, 0, "R6 survive");
    readAll("R6 end");
    pass(0, "R6 rel");
    passWithRead(0, 2'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule